// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into the timing of one nominal CAN bit. A prescaler divides the clock down to the time quantum. A segment sequencer then walks through four segments in a fixed order: synchronization, propagation, phase 1 and phase 2. It raises a one-cycle sample strobe when phase 1 ends. It raises a one-cycle bit-start strobe, together with a transmit-drive strobe, each time a new bit begins. A bit controller uses the strobes: it samples the receive line on the sample strobe, and it changes its driven level on the transmit strobe.

The receive line is watched for recessive-to-dominant (1 to 0) transitions. When hard synchronization is enabled, such a transition restarts the bit at the synchronization segment. In all other cases, a transition outside the synchronization segment resynchronizes the bit. A late transition stretches phase 1 and an early one trims phase 2. The correction is limited by the jump width, and only the first transition in a bit is used. A configuration whose total bit time is below eight quanta is flagged, and the sequencer is then held idle.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2*(brp+1) clock cycles. With no resynchronization, consecutive `bit_start` pulses are tq*(4+prop_len+ph1_len+ph2_len) cycles apart. Each length field encodes its value minus one, and the synchronization segment is always one quantum.
- R2: `sample_stb` pulses tq*(3+prop_len+ph1_len) cycles after `bit_start`, at the end of phase 1. It never coincides with `bit_start`.
- R3: `cfg_bad` is high exactly when 4+prop_len+ph1_len+ph2_len is below 8. While it is high, no strobe is produced. The largest setting (25 quanta) is accepted.
- R4: Without hard sync, a 1-to-0 transition seen in quantum k of the bit, where k ≥ 1 lies in propagation or phase 1, lengthens phase 1 by min(k, sjw+1) quanta.
- R5: Without hard sync, a 1-to-0 transition seen in phase-2 quantum j (counted from 0) shortens phase 2 by min(ph2_len-j, sjw+1) quanta.
- R6: A 1-to-0 transition inside the synchronization quantum changes nothing. A 0-to-1 transition changes nothing. Only the first resynchronizing transition of a bit is used.
- R7: With `hard_sync_en` high, a 1-to-0 transition makes `bit_start` pulse in the next cycle with `tx_stb` low. A full nominal bit follows from that point.
- R8: `tx_stb` pulses together with every `bit_start` that ends a bit normally, and at no other time.
- R9: On a `sample_stb` pulse, `sample_val` holds the level of `rx` at the clock edge that ended phase 1.
- R10: During and straight after reset, all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brp | input | BRP_W | Prescaler; quantum is 2*(brp+1) clocks |
| prop_len | input | LEN_W | Propagation segment length minus one |
| ph1_len | input | LEN_W | Phase 1 length minus one |
| ph2_len | input | LEN_W | Phase 2 length minus one |
| sjw | input | SJW_W | Jump width minus one |
| hard_sync_en | input | 1 | Bus idle: falling edges hard-synchronize |
| rx | input | 1 | Receive line, already synchronized to clk |
| cfg_bad | output | 1 | Bit time below minimum |
| sample_stb | output | 1 | Sample point pulse |
| sample_val | output | 1 | rx value captured at the sample point |
| bit_start | output | 1 | Start of a bit |
| tx_stb | output | 1 | Transmit drive pulse at normal bit boundaries |

## Verification
The assertions assume that `rx` is already synchronous to `clk`, so an edge is defined by `rx` over two consecutive clock edges. They also assume that the timing fields change only while the block is held in reset. The bench follows both rules. Every configuration is applied inside a reset pulse, and `rx` is driven only on falling clock edges. Each `rx` transition is placed a known number of cycles after a `bit_start`, so the quantum in which it lands follows from R1.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W  = 6,
  parameter int LEN_W  = 3,
  parameter int SJW_W  = 2,
  parameter int MIN_TQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp,
  input  logic [LEN_W-1:0] prop_len,
  input  logic [LEN_W-1:0] ph1_len,
  input  logic [LEN_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw,
  input  logic             hard_sync_en,
  input  logic             rx,
  output logic             cfg_bad,
  output logic             sample_stb,
  output logic             sample_val,
  output logic             bit_start,
  output logic             tx_stb
);
  localparam int PW = BRP_W + 1;
  localparam int QW = ((LEN_W > SJW_W) ? LEN_W : SJW_W) + 2;
  localparam int EW = QW + 1;
  localparam int TW = LEN_W + 3;

  typedef enum logic [1:0] {SEG_SYNC, SEG_PROP, SEG_PH1, SEG_PH2} seg_t;

  seg_t          seg;
  logic [PW-1:0] pcnt;
  logic [QW-1:0] qcnt, ext, cut, ext_n, cut_n, seg_len;
  logic          used, rx_q;

  wire [QW-1:0] prop_q = QW'(prop_len) + QW'(1);
  wire [QW-1:0] ph1_q  = QW'(ph1_len) + QW'(1);
  wire [QW-1:0] ph2_q  = QW'(ph2_len) + QW'(1);
  wire [QW-1:0] sjw_q  = QW'(sjw) + QW'(1);
  wire [TW-1:0] total  = TW'(prop_len) + TW'(ph1_len) + TW'(ph2_len) + TW'(4);

  assign cfg_bad = total < TW'(MIN_TQ);

  wire tq_last   = pcnt == {brp, 1'b1};
  wire edge_fall = rx_q & ~rx;
  wire hard      = edge_fall & hard_sync_en & ~cfg_bad;
  wire resync    = edge_fall & ~hard_sync_en & ~used & (seg != SEG_SYNC) & ~cfg_bad;

  wire [EW-1:0] late_err  = (seg == SEG_PROP) ? EW'(qcnt) + EW'(1)
                                              : EW'(prop_q) + EW'(qcnt) + EW'(1);
  wire [QW-1:0] early_err = ph2_q - qcnt - QW'(1);

  always_comb begin
    ext_n = ext;
    cut_n = cut;
    if (resync && seg != SEG_PH2)
      ext_n = (late_err < EW'(sjw_q)) ? QW'(late_err) : sjw_q;
    if (resync && seg == SEG_PH2)
      cut_n = (early_err < sjw_q) ? early_err : sjw_q;
    case (seg)
      SEG_SYNC: seg_len = QW'(1);
      SEG_PROP: seg_len = prop_q;
      SEG_PH1:  seg_len = ph1_q + ext_n;
      default:  seg_len = ph2_q - cut_n;
    endcase
  end

  wire seg_end = tq_last && ((qcnt + QW'(1)) >= seg_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg <= SEG_SYNC;
      pcnt <= '0;
      qcnt <= '0;
      ext <= '0;
      cut <= '0;
      used <= 1'b0;
      rx_q <= 1'b1;
      sample_stb <= 1'b0;
      sample_val <= 1'b1;
      bit_start <= 1'b0;
      tx_stb <= 1'b0;
    end else begin
      rx_q <= rx;
      sample_stb <= 1'b0;
      bit_start <= 1'b0;
      tx_stb <= 1'b0;
      if (cfg_bad || hard) begin
        seg <= SEG_SYNC;
        pcnt <= '0;
        qcnt <= '0;
        ext <= '0;
        cut <= '0;
        used <= hard;
        bit_start <= hard;
      end else begin
        ext <= ext_n;
        cut <= cut_n;
        if (resync) used <= 1'b1;
        if (!tq_last) begin
          pcnt <= pcnt + PW'(1);
        end else begin
          pcnt <= '0;
          if (!seg_end) begin
            qcnt <= qcnt + QW'(1);
          end else begin
            qcnt <= '0;
            case (seg)
              SEG_SYNC: seg <= SEG_PROP;
              SEG_PROP: seg <= SEG_PH1;
              SEG_PH1: begin
                seg <= SEG_PH2;
                sample_stb <= 1'b1;
                sample_val <= rx;
              end
              default: begin
                seg <= SEG_SYNC;
                bit_start <= 1'b1;
                tx_stb <= 1'b1;
                ext <= '0;
                cut <= '0;
                used <= 1'b0;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx,
  input logic hard_sync_en,
  input logic cfg_bad,
  input logic sample_stb,
  input logic sample_val,
  input logic bit_start,
  input logic tx_stb
);
  AST_TX_WITH_START: assert property (@(posedge clk) disable iff (!rst_n) tx_stb |-> bit_start); // R8
  AST_SAMPLE_APART: assert property (@(posedge clk) disable iff (!rst_n) !(sample_stb && bit_start)); // R2
  AST_SAMPLE_VALUE: assert property (@(posedge clk) disable iff (!rst_n) sample_stb |-> sample_val == $past(rx)); // R9
  AST_QUIET_WHEN_BAD: assert property (@(posedge clk) disable iff (!rst_n) (cfg_bad && $past(cfg_bad)) |-> !(bit_start || sample_stb)); // R3
  AST_HARD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hard_sync_en) && $past(rx, 2) && !$past(rx) && !$past(cfg_bad) && $past(rst_n)) |-> (bit_start && !tx_stb)); // R7
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx(rx), .hard_sync_en(hard_sync_en), .cfg_bad(cfg_bad),
  .sample_stb(sample_stb), .sample_val(sample_val), .bit_start(bit_start), .tx_stb(tx_stb)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] brp = '0;
  logic [2:0] prop_len = 3'd1, ph1_len = 3'd2, ph2_len = 3'd2;
  logic [1:0] sjw = 2'd1;
  logic hard_sync_en = 1'b0;
  logic rx = 1'b1;
  logic cfg_bad, sample_stb, sample_val, bit_start, tx_stb;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .brp(brp), .prop_len(prop_len), .ph1_len(ph1_len),
    .ph2_len(ph2_len), .sjw(sjw), .hard_sync_en(hard_sync_en), .rx(rx),
    .cfg_bad(cfg_bad), .sample_stb(sample_stb), .sample_val(sample_val),
    .bit_start(bit_start), .tx_stb(tx_stb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input int b, input int p, input int a, input int c, input int s);
    @(negedge clk);
    rst_n = 1'b0;
    rx = 1'b1;
    brp = 6'(b); prop_len = 3'(p); ph1_len = 3'(a); ph2_len = 3'(c); sjw = 2'(s);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_start(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (bit_start) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_bit(input int fall1, input int rise1, input int fall2,
                         output int t_samp, output int t_next, output int sval);
    t_samp = -1; t_next = -1; sval = -1;
    for (int n = 0; n < 2000; n++) begin
      if (n == fall1 || n == fall2) rx = 1'b0;
      if (n == rise1) rx = 1'b1;
      @(negedge clk);
      if (sample_stb) begin t_samp = n + 1; sval = int'(sample_val); end
      if (bit_start) begin t_next = n + 1; break; end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!bit_start && !sample_stb && !tx_stb, "R10", int'({bit_start, sample_stb, tx_stb}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bit_start && !sample_stb && !tx_stb, "R10", int'({bit_start, sample_stb, tx_stb}), 0);
  endtask

  task automatic t_nominal(input int b, input int p, input int a, input int c, input string tag);
    bit ok; int ts, tn, sv;
    int tq = 2 * (b + 1);
    apply_cfg(b, p, a, c, 1);
    wait_start(ok);
    check(ok, tag, int'(ok), 1);
    check(tx_stb == 1'b1, "R8", int'(tx_stb), 1);
    run_bit(-1, -1, -1, ts, tn, sv);
    check(tn == tq * (4 + p + a + c), tag, tn, tq * (4 + p + a + c));
    check(ts == tq * (3 + p + a), "R2", ts, tq * (3 + p + a));
    check(cfg_bad == 1'b0, "R3", int'(cfg_bad), 0);
  endtask

  task automatic t_bad_cfg;
    int seen = 0;
    apply_cfg(0, 1, 1, 1, 1);
    @(negedge clk);
    check(cfg_bad == 1'b1, "R3", int'(cfg_bad), 1);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (bit_start || sample_stb || tx_stb) seen++;
    end
    check(seen == 0, "R3", seen, 0);
  endtask

  task automatic t_resync(input int s, input int f1, input int r1, input int f2,
                          input int exp_len, input string tag);
    bit ok; int ts, tn, sv;
    apply_cfg(0, 1, 2, 2, s);
    wait_start(ok);
    run_bit(f1, r1, f2, ts, tn, sv);
    check(tn == exp_len, tag, tn, exp_len);
    rx = 1'b1;
    run_bit(-1, -1, -1, ts, tn, sv);
    check(tn == 18, tag, tn, 18);
  endtask

  task automatic t_late_sample;
    bit ok; int ts, tn, sv;
    apply_cfg(0, 1, 2, 2, 1);
    wait_start(ok);
    run_bit(6, -1, -1, ts, tn, sv);
    check(ts == 16, "R4", ts, 16);
    rx = 1'b1;
  endtask

  task automatic t_hard_sync;
    bit ok; int ts, tn, sv;
    apply_cfg(0, 1, 2, 2, 1);
    hard_sync_en = 1'b1;
    wait_start(ok);
    repeat (10) @(negedge clk);
    rx = 1'b0;
    @(negedge clk);
    check(bit_start == 1'b1, "R7", int'(bit_start), 1);
    check(tx_stb == 1'b0, "R7", int'(tx_stb), 0);
    run_bit(-1, 3, -1, ts, tn, sv);
    check(tn == 18, "R7", tn, 18);
    check(tx_stb == 1'b1, "R8", int'(tx_stb), 1);
    hard_sync_en = 1'b0;
  endtask

  task automatic t_sample_value;
    bit ok; int ts, tn, sv;
    apply_cfg(0, 1, 2, 2, 1);
    wait_start(ok);
    run_bit(0, 14, -1, ts, tn, sv);
    check(sv == 0, "R9", sv, 0);
    check(tn == 18, "R6", tn, 18);
    run_bit(-1, -1, -1, ts, tn, sv);
    check(sv == 1, "R9", sv, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_nominal(0, 1, 2, 2, "R1");
    t_nominal(2, 1, 2, 2, "R1");
    t_nominal(0, 7, 7, 7, "R3");
    t_nominal(0, 2, 1, 1, "R3");
    t_bad_cfg();
    t_resync(1, 0, -1, -1, 18, "R6");
    t_resync(1, 2, -1, -1, 20, "R4");
    t_resync(1, 6, -1, -1, 22, "R4");
    t_resync(0, 6, -1, -1, 20, "R4");
    t_resync(1, 12, -1, -1, 14, "R5");
    t_resync(1, 14, -1, -1, 16, "R5");
    t_resync(0, 12, -1, -1, 16, "R5");
    t_resync(1, 2, 4, 6, 20, "R6");
    t_late_sample();
    t_hard_sync();
    t_sample_value();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule